// File: doc/BRIEF.md
# Four-Way Data Cache with Run-Time Write Policy

The block is a blocking data cache between a processor's load/store port and a line-oriented memory port. It holds 8 KB as 32 sets of four 64-byte lines. Each line keeps a tag, a valid bit and a dirty bit. Each set keeps a full least-recently-used ordering of its four ways. A load or store is taken on a valid/ready handshake. A load hit answers with one word two cycles after acceptance. A miss stalls the request port until the line is in place.

The input `cfg_write_through` is sampled when each request is accepted. At 0 the cache is write-back: a store hit updates only the line and marks it dirty, and a dirty victim is written out as a whole line before its replacement is fetched. At 1 the cache is write-through: every store also goes to memory as a byte-masked line write, and a store that misses does not allocate a line. Lines that were made dirty earlier still write back when they are evicted.

The controller states are IDLE (ready for a request), LOOKUP (tag compare of the indexed set; the hit, the hit way and the LRU victim are registered), RESOLVE (hit: answer the load or write the store's bytes; miss: choose a path), EVICT (send the dirty victim), FILL_REQ (ask for the line), FILL_WAIT (install the returned line) and WT_SEND (forward a store). The transitions are:
- IDLE→LOOKUP on an accepted request.
- LOOKUP→RESOLVE always.
- RESOLVE→IDLE on a load hit, or on a store hit in write-back mode.
- RESOLVE→WT_SEND on any store in write-through mode.
- RESOLVE→EVICT on a miss whose victim is dirty.
- RESOLVE→FILL_REQ on a miss whose victim is clean.
- EVICT→FILL_REQ and FILL_REQ→FILL_WAIT when the memory port accepts.
- FILL_WAIT→LOOKUP on the line response, which replays the request.
- WT_SEND→IDLE when the memory port accepts.

Top module: `wpc_cache_top`

## Requirements
- R1: A load returns the 32-bit word at its address as last written by earlier stores, with only the enabled byte lanes changed by each store. Address fields are: byte in line [5:0], word in line [5:2], set [10:6], tag [31:11].
- R2: A load that hits raises `resp_valid` for one cycle, after the second rising edge that follows the accepting edge.
- R3: On a miss the replaced way is the least recently used way of the set. Every hit and every refill makes that way the most recently used.
- R4: In write-back mode (`cfg_write_through`=0) a store hit updates only the cached line and marks it dirty; it causes no memory request.
- R5: A miss whose victim is dirty first issues a line write of the victim (`mem_req_be` all 64 bits set, `mem_req_addr` = victim line address) and only then issues the refill read.
- R6: A clean victim is replaced without any memory write.
- R7: In write-through mode (`cfg_write_through`=1) every store issues exactly one memory write. `mem_req_addr` is the store address, `mem_req_data` holds the store word in every word slot, and `mem_req_be` bit (4·addr[5:2]+i) equals `req_be[i]`, with all other bits zero. A store hit also updates the cached line.
- R8: In write-through mode a store miss issues no refill read and allocates no line, so a later load of that address misses.
- R9: Lines made dirty in write-back mode are still written back when evicted after a switch to write-through.
- R10: Only one request is in flight: `req_ready` is low from the accepting edge until the request is finished. A memory request that is not accepted keeps its valid, address and direction.
- R11: After reset `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_write_through | input | 1 | 1 selects write-through, 0 write-back; sampled per request |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can take a request |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Store byte enables |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Load data valid, one cycle |
| resp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 line read |
| mem_req_addr | output | 32 | Line address, or store address for a forwarded store |
| mem_req_be | output | 64 | Byte enables over the line |
| mem_req_data | output | 512 | Write data over the line |
| mem_rsp_valid | input | 1 | Refill line present, one cycle |
| mem_rsp_data | input | 512 | Refill line |

## Verification
Checked on every cycle:
- a load hit's two-cycle answer;
- the stalled request port;
- a memory request held steady until it is accepted;
- entry into eviction only with a valid dirty victim;
- a write-through store miss going straight to forwarding;
- installed lines arriving clean;
- exactly one LRU victim per set, with the touched way becoming the most recent.

Only the bench scenarios can show:
- which way a replacement picks after a chosen access order;
- that write-back store hits produce no memory traffic;
- that a dirty victim's write precedes its refill and carries the stored bytes;
- the byte-mask placement of forwarded stores;
- that a write-through store miss leaves no line behind;
- that dirty lines made before a mode switch still reach memory.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_RESOLVE,
        ST_EVICT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_WT_SEND
    } wpc_state_e;
endpackage

// File: rtl/wpc_lru.sv
// Per-set age ranks: 0 = most recent, WAYS-1 = victim.
module wpc_lru #(
    parameter int SETS = 32,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim_way
);
    logic [WAY_W-1:0] rank_q [SETS][WAYS];
    logic [WAYS-1:0]  victim_oh;

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            victim_oh[w] = (rank_q[set_idx][w] == WAY_W'(WAYS - 1));
            if (victim_oh[w]) victim_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[set_idx][w] <= '0;
                else if (rank_q[set_idx][w] < rank_q[set_idx][touch_way])
                    rank_q[set_idx][w] <= rank_q[set_idx][w] + 1'b1;
            end
        end
    end

    a_r3_victim_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(victim_oh));

    a_r3_touch_mru: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> rank_q[$past(set_idx)][$past(touch_way)] == '0);
endmodule

// File: rtl/wpc_arrays.sv
module wpc_arrays #(
    parameter int SETS       = 32,
    parameter int WAYS       = 4,
    parameter int TAG_W      = 21,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WORD_W = $clog2(LINE_BYTES / WORD_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            set_idx,
    input  logic [WAY_W-1:0]            rd_way,
    output logic [WAYS-1:0][TAG_W-1:0]  set_tag,
    output logic [WAYS-1:0]             set_valid,
    output logic [WAYS-1:0]             set_dirty,
    output logic [LINE_W-1:0]           rd_line,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [WORD_W-1:0]           wr_word,
    input  logic [WORD_BYTES-1:0]       wr_be,
    input  logic [WORD_BYTES*8-1:0]     wr_data,
    input  logic                        mark_dirty,
    input  logic                        fill_en,
    input  logic [WAY_W-1:0]            fill_way,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [LINE_W-1:0]           fill_data
);
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [LINE_W-1:0] data_q  [SETS*WAYS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tag[w] = tag_q[set_idx][w];
        set_valid = valid_q[set_idx];
        set_dirty = dirty_q[set_idx];
        rd_line   = data_q[{set_idx, rd_way}];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (fill_en) begin
            valid_q[set_idx][fill_way] <= 1'b1;
            dirty_q[set_idx][fill_way] <= 1'b0;
        end else if (wr_en && mark_dirty) begin
            dirty_q[set_idx][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[set_idx][fill_way]      <= fill_tag;
            data_q[{set_idx, fill_way}]   <= fill_data;
        end else if (wr_en) begin
            for (int b = 0; b < WORD_BYTES; b++)
                if (wr_be[b])
                    data_q[{set_idx, wr_way}][(int'(wr_word) * WORD_BYTES + b) * 8 +: 8] <= wr_data[b*8 +: 8];
        end
    end

    a_r4_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid_q[$past(set_idx)][$past(fill_way)] && !dirty_q[$past(set_idx)][$past(fill_way)]);
endmodule

// File: rtl/wpc_cache_top.sv
module wpc_cache_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int WAYS       = 4,
    parameter int SETS       = 32,
    localparam int WORD_BYTES = DATA_W / 8,
    localparam int LINE_W     = LINE_BYTES * 8,
    localparam int WORDS      = LINE_BYTES / WORD_BYTES,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int IDX_W      = $clog2(SETS),
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W,
    localparam int WB_W       = $clog2(WORD_BYTES),
    localparam int WORD_W     = $clog2(WORDS),
    localparam int WAY_W      = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_write_through,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_BYTES-1:0] req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  resp_valid,
    output logic [DATA_W-1:0]     resp_rdata,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic [ADDR_W-1:0]     mem_req_addr,
    output logic [LINE_BYTES-1:0] mem_req_be,
    output logic [LINE_W-1:0]     mem_req_data,
    input  logic                  mem_rsp_valid,
    input  logic [LINE_W-1:0]     mem_rsp_data
);
    import wpc_pkg::*;

    wpc_state_e state_q, state_d;

    logic [ADDR_W-1:0]     addr_q;
    logic                  wr_q, pol_q;
    logic [WORD_BYTES-1:0] be_q;
    logic [DATA_W-1:0]     wdata_q;
    logic                  hit_q;
    logic [WAY_W-1:0]      hit_way_q, victim_q;
    logic                  resp_valid_q;
    logic [DATA_W-1:0]     resp_rdata_q;

    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag;
    logic [WORD_W-1:0] word;
    assign set_idx = addr_q[OFF_W +: IDX_W];
    assign tag     = addr_q[ADDR_W-1 -: TAG_W];
    assign word    = addr_q[WB_W +: WORD_W];

    logic [WAYS-1:0][TAG_W-1:0] set_tag;
    logic [WAYS-1:0]            set_valid, set_dirty;
    logic [LINE_W-1:0]          rd_line;
    logic [WAY_W-1:0]           rd_way, victim_way, touch_way;
    logic                       wr_en, mark_dirty, fill_en, touch_en;
    logic [WAYS-1:0]            hit_vec;
    logic [WAY_W-1:0]           hit_idx;
    logic                       victim_dirty;

    // Tag compare of the indexed set
    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = set_valid[w] && (set_tag[w] == tag);
            if (hit_vec[w]) hit_idx = WAY_W'(w);
        end
    end

    assign victim_dirty = set_valid[victim_q] && set_dirty[victim_q];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:    state_d = ST_RESOLVE;
            ST_RESOLVE: begin
                if (wr_q && pol_q)     state_d = ST_WT_SEND;
                else if (hit_q)        state_d = ST_IDLE;
                else if (victim_dirty) state_d = ST_EVICT;
                else                   state_d = ST_FILL_REQ;
            end
            ST_EVICT:     if (mem_req_ready) state_d = ST_FILL_REQ;
            ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_WAIT;
            ST_FILL_WAIT: if (mem_rsp_valid) state_d = ST_LOOKUP;
            ST_WT_SEND:   if (mem_req_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs and array controls
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_req_be    = '0;
        mem_req_data  = '0;
        wr_en         = 1'b0;
        fill_en       = 1'b0;
        rd_way        = hit_way_q;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_LOOKUP:  ;
            ST_RESOLVE: wr_en = hit_q && wr_q;
            ST_EVICT: begin
                rd_way        = victim_q;
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {set_tag[victim_q], set_idx, {OFF_W{1'b0}}};
                mem_req_be    = '1;
                mem_req_data  = rd_line;
            end
            ST_FILL_REQ:  mem_req_valid = 1'b1;
            ST_FILL_WAIT: fill_en = mem_rsp_valid;
            ST_WT_SEND: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = addr_q;
                mem_req_be    = {{(LINE_BYTES-WORD_BYTES){1'b0}}, be_q} << {word, {WB_W{1'b0}}};
                mem_req_data  = {WORDS{wdata_q}};
            end
            default: ;
        endcase
        mark_dirty = wr_en && !pol_q;
        touch_en   = (state_q == ST_RESOLVE && hit_q) || fill_en;
        touch_way  = fill_en ? victim_q : hit_way_q;
    end

    // Request, lookup and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q       <= '0;
            wr_q         <= 1'b0;
            pol_q        <= 1'b0;
            be_q         <= '0;
            wdata_q      <= '0;
            hit_q        <= 1'b0;
            hit_way_q    <= '0;
            victim_q     <= '0;
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wr_q    <= req_write;
                pol_q   <= cfg_write_through;
                be_q    <= req_be;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_LOOKUP) begin
                hit_q     <= |hit_vec;
                hit_way_q <= hit_idx;
                victim_q  <= victim_way;
            end
            if (state_q == ST_RESOLVE && hit_q && !wr_q) begin
                resp_valid_q <= 1'b1;
                resp_rdata_q <= rd_line[int'(word) * DATA_W +: DATA_W];
            end
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_rdata = resp_rdata_q;

    wpc_arrays #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
        .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
    ) u_arrays (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .rd_way(rd_way),
        .set_tag(set_tag), .set_valid(set_valid), .set_dirty(set_dirty), .rd_line(rd_line),
        .wr_en(wr_en), .wr_way(hit_way_q), .wr_word(word), .wr_be(be_q), .wr_data(wdata_q),
        .mark_dirty(mark_dirty), .fill_en(fill_en), .fill_way(victim_q), .fill_tag(tag),
        .fill_data(mem_rsp_data)
    );

    wpc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx),
        .touch_en(touch_en), .touch_way(touch_way), .victim_way(victim_way)
    );

    a_r2_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && req_ready && !req_write, 3) && $past(hit_q)) |-> resp_valid);

    a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    a_r5_evict_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT) |-> (set_valid[victim_q] && set_dirty[victim_q]));

    a_r8_wt_miss_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE && !hit_q && wr_q && pol_q) |=> state_q == ST_WT_SEND);
endmodule

// File: tb/tb_wpc_cache_top.sv
module tb_wpc_cache_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_write_through = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [3:0]   req_be = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic         mem_req_write;
    logic [31:0]  mem_req_addr;
    logic [63:0]  mem_req_be;
    logic [511:0] mem_req_data;
    logic         mem_rsp_valid = 1'b0;
    logic [511:0] mem_rsp_data = '0;

    wpc_cache_top dut (.*);

    always #10 clk = ~clk;  // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // Memory model
    logic [511:0] mem_lines [256];
    int wr_cnt = 0, rd_cnt = 0, ev = 0, wr_seq = 0, rd_seq = 0;
    logic [31:0] last_wr_addr = '0;
    logic [63:0] last_wr_be = '0;
    bit rsp_pend = 1'b0;
    int rsp_dly = 0, mcnt = 0;
    logic [511:0] rsp_line;

    always @(negedge clk) begin
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        else if (rsp_pend) begin
            if (rsp_dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rsp_line;
                rsp_pend      = 1'b0;
            end else rsp_dly--;
        end
        mcnt++;
        mem_req_ready = (mcnt % 3 != 2);
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                for (int b = 0; b < 64; b++)
                    if (mem_req_be[b])
                        mem_lines[mem_req_addr[13:6]][b*8 +: 8] = mem_req_data[b*8 +: 8];
                wr_cnt++; wr_seq = ev++;
                last_wr_addr = mem_req_addr;
                last_wr_be   = mem_req_be;
            end else begin
                rsp_line = mem_lines[mem_req_addr[13:6]];
                rsp_pend = 1'b1;
                rsp_dly  = 2;
                rd_cnt++; rd_seq = ev++;
            end
        end
    end

    // Reference view of memory
    logic [31:0] ref_mem [int];
    function automatic logic [31:0] ref_word(input logic [31:0] a);
        int k = int'(a >> 2);
        return ref_mem.exists(k) ? ref_mem[k] : init_word({a[31:2], 2'b00});
    endfunction

    typedef struct {
        logic [31:0] addr;
        logic [31:0] exp;
        bit          lat;
        int          acc;
    } item_t;
    item_t exp_q[$];

    // Monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R1", "unexpected response", 64'(resp_rdata), 0);
            else begin
                item_t it;
                it = exp_q.pop_front();
                check(resp_rdata == it.exp, "R1", "load data", 64'(resp_rdata), 64'(it.exp));
                if (it.lat) check(cyc - it.acc == 2, "R2", "hit latency", 64'(cyc - it.acc), 2);
            end
        end
    end

    task automatic send(input bit w, input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        bit rdy;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
        forever begin
            rdy = req_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_req();
        @(negedge clk);
        req_valid = 1'b0;
        while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
    endtask

    // Driver: pushes the expected word for each load
    task automatic do_load(input logic [31:0] a, input bit hit_exp);
        item_t it;
        send(1'b0, a, 4'h0, '0);
        @(negedge clk);
        it.addr = a; it.exp = ref_word(a); it.lat = hit_exp; it.acc = cyc;
        exp_q.push_back(it);
        req_valid = 1'b0;
        while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] v;
        v = ref_word(a);
        for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = d[b*8 +: 8];
        ref_mem[int'(a >> 2)] = v;
        send(1'b1, a, be, d);
        finish_req();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R10", "watchdog expired", 0, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int r, w;
        for (int i = 0; i < 256; i++)
            for (int k = 0; k < 16; k++)
                mem_lines[i][k*32 +: 32] = init_word(32'(i * 64 + k * 4));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1, "R11", "req_ready after reset", 64'(req_ready), 1);
        check(resp_valid == 1'b0, "R11", "resp_valid after reset", 64'(resp_valid), 0);
        check(mem_req_valid == 1'b0, "R11", "mem_req_valid after reset", 64'(mem_req_valid), 0);

        // Write-back mode
        cfg_write_through = 1'b0;
        r = rd_cnt;
        do_load(32'h040, 1'b0);
        check(rd_cnt == r + 1, "R11", "first load refills (lines invalid)", 64'(rd_cnt), 64'(r + 1));
        do_load(32'h040, 1'b1);
        check(rd_cnt == r + 1, "R2", "hit needs no read", 64'(rd_cnt), 64'(r + 1));
        w = wr_cnt;
        do_store(32'h044, 32'hDEAD_BEEF, 4'hF);
        do_store(32'h048, 32'h1122_3344, 4'b0101);
        check(wr_cnt == w, "R4", "store hits write nothing", 64'(wr_cnt), 64'(w));
        do_load(32'h044, 1'b1);
        do_load(32'h048, 1'b1);
        do_load(32'h840, 1'b0);
        do_load(32'h1040, 1'b0);
        do_load(32'h1840, 1'b0);
        check(wr_cnt == w, "R6", "no writes while filling", 64'(wr_cnt), 64'(w));
        r = rd_cnt;
        do_load(32'h2040, 1'b0);
        check(wr_cnt == w + 1, "R5", "dirty victim written", 64'(wr_cnt), 64'(w + 1));
        check(last_wr_addr == 32'h040, "R5", "victim address", 64'(last_wr_addr), 64'h40);
        check(last_wr_be == '1, "R5", "victim full mask", last_wr_be, 64'hFFFF_FFFF_FFFF_FFFF);
        check(wr_seq < rd_seq, "R5", "writeback before refill", 64'(wr_seq), 64'(rd_seq));
        check(mem_lines[1][63:32] == 32'hDEAD_BEEF, "R5", "victim data", 64'(mem_lines[1][63:32]), 64'hDEADBEEF);

        // R3 LRU order: set now holds E,D,C,B with B least recent
        do_load(32'h840, 1'b1);
        w = wr_cnt;
        do_load(32'h040, 1'b0);
        check(wr_cnt == w, "R6", "clean victim not written", 64'(wr_cnt), 64'(w));
        r = rd_cnt;
        do_load(32'h840, 1'b1);
        check(rd_cnt == r, "R3", "touched way kept", 64'(rd_cnt), 64'(r));
        do_load(32'h1040, 1'b0);
        check(rd_cnt == r + 1, "R3", "least recent way replaced", 64'(rd_cnt), 64'(r + 1));
        do_load(32'h2040, 1'b1);
        check(rd_cnt == r + 1, "R3", "recent way kept", 64'(rd_cnt), 64'(r + 1));

        // Write-through mode
        cfg_write_through = 1'b1;
        do_load(32'h100, 1'b0);
        w = wr_cnt;
        do_store(32'h10C, 32'hCAFE_F00D, 4'hF);
        check(wr_cnt == w + 1, "R7", "store forwarded", 64'(wr_cnt), 64'(w + 1));
        check(last_wr_addr == 32'h10C, "R7", "store address", 64'(last_wr_addr), 64'h10C);
        check(last_wr_be == 64'hF000, "R7", "word mask", last_wr_be, 64'hF000);
        check(mem_lines[4][127:96] == 32'hCAFE_F00D, "R7", "memory word", 64'(mem_lines[4][127:96]), 64'hCAFEF00D);
        do_load(32'h10C, 1'b1);
        do_store(32'h110, 32'hAABB_CCDD, 4'b1000);
        check(last_wr_be == 64'h8_0000, "R7", "byte mask", last_wr_be, 64'h80000);
        w = wr_cnt;
        do_load(32'h900, 1'b0);
        do_load(32'h1100, 1'b0);
        do_load(32'h1900, 1'b0);
        do_load(32'h2100, 1'b0);
        check(wr_cnt == w, "R7", "write-through line evicted clean", 64'(wr_cnt), 64'(w));
        do_load(32'h10C, 1'b0);
        do_load(32'h110, 1'b0);

        // R8 store miss without allocation
        r = rd_cnt; w = wr_cnt;
        do_store(32'h180, 32'h1234_5678, 4'hF);
        check(rd_cnt == r, "R8", "no refill on store miss", 64'(rd_cnt), 64'(r));
        check(wr_cnt == w + 1, "R8", "store miss forwarded", 64'(wr_cnt), 64'(w + 1));
        fork
            do_load(32'h180, 1'b0);
            begin
                repeat (4) @(negedge clk);
                check(req_ready == 1'b0, "R10", "ready low during miss", 64'(req_ready), 0);
            end
        join
        check(rd_cnt == r + 1, "R8", "later load misses", 64'(rd_cnt), 64'(r + 1));

        // R9 dirty line survives mode switch
        cfg_write_through = 1'b0;
        do_load(32'h1C0, 1'b0);
        do_store(32'h1E0, 32'h0BAD_F00D, 4'hF);
        cfg_write_through = 1'b1;
        w = wr_cnt;
        do_load(32'h9C0, 1'b0);
        do_load(32'h11C0, 1'b0);
        do_load(32'h19C0, 1'b0);
        check(wr_cnt == w, "R9", "no write before eviction", 64'(wr_cnt), 64'(w));
        do_load(32'h21C0, 1'b0);
        check(wr_cnt == w + 1, "R9", "dirty line written on eviction", 64'(wr_cnt), 64'(w + 1));
        check(last_wr_addr == 32'h1C0, "R9", "evicted address", 64'(last_wr_addr), 64'h1C0);
        check(mem_lines[7][287:256] == 32'h0BAD_F00D, "R9", "evicted data", 64'(mem_lines[7][287:256]), 64'h0BADF00D);
        do_load(32'h1E0, 1'b0);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule